// File: doc/BRIEF.md
# Board Interconnect Test Sequencer and Fault Diagnoser

This block checks the wiring between boundary scan devices on a board. It has a parameter N, the number of nets under test. A one-cycle start pulse launches a short sequence of parallel test vectors, one per step. Over the sequence, each net carries a serial code that no other net carries. At every step the block samples the values that arrive at the far end of the nets. When the sequence ends, it compares each net's received code with the code it sent. It then sorts each failing net into one of two classes: open or shorted.

Net i is given the base code i+1 in clog2(N+2) bits. This keeps every code distinct and never all-zeros or all-ones, so no code can be confused with a stuck net. One extra step follows the base code and carries a parity bit that makes the total number of ones odd. Under wired-AND bridging, this makes it harder for a merged result to pass as some net's valid code. Opens are assumed to read as a constant 0.

The verdict is reported on `done` and on per-net `open_flags` and `short_flags`. These outputs stay unchanged until the next start.

Top module: `net_test_diag`

## Requirements
- R1: The sequence has CODE_W = clog2(N+2)+1 steps (5 when N is 12). In step s, `drive[i]` carries bit s of net i's code, sent LSB first. Bits [CODE_W-2:0] of the code hold i+1. Bit CODE_W-1 is set so that the whole code has an odd number of ones.
- R2: Step 0 is driven from the clock edge that sees `start`. Each later step follows on the next edge. `sense` is sampled on the edge that ends each step. `done` rises on the CODE_W-th edge after the start edge.
- R3: `drive` is all zeros whenever no sequence is running, including after `done`.
- R4: A net whose received code is all zeros is reported with its `open_flags` bit set.
- R5: A net whose received code is non-zero and differs from its own code is reported with its `short_flags` bit set. No net ever has both flags set.
- R6: When every net receives exactly what it was driven, both flag vectors read zero at `done`.
- R7: `done` and both flag vectors hold their values, whatever `sense` does, until the next `start`. The edge that sees `start` clears all three.
- R8: A `start` that arrives during a running sequence restarts it from step 0. The verdict is then due CODE_W edges after the new start.
- R9: After reset, `done`, `drive`, `open_flags` and `short_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts a test sequence |
| sense | input | N | Values received at the far end of the nets |
| drive | output | N | Test vector for the current step |
| done | output | 1 | Verdict valid; held until the next start |
| open_flags | output | N | Per-net open verdict |
| short_flags | output | N | Per-net short verdict |

## Verification
The start edge is counted as edge 0. The vector for step s appears just after edge s. The bench compares it with its own code table at the falling edge that follows. At that same falling edge it checks that `done` is still low. `done` and the flags are due just after edge CODE_W, so the bench reads them at the falling edge after that edge. It also confirms that they were cleared after edge 0 and that they stay frozen during later idle cycles. In the restart case, all of these counts begin again at the second start edge.

// File: rtl/net_test_pkg.sv
package net_test_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // Code for net idx: base idx+1 in base_w bits, top bit makes ones-count odd.
  function automatic logic [31:0] net_code(int unsigned idx, int unsigned base_w);
    logic [31:0] base;
    logic [31:0] mask;
    logic        par;
    mask = (32'd1 << base_w) - 32'd1;
    base = (idx + 32'd1) & mask;
    par  = ~(^base);
    return base | ({31'd0, par} << base_w);
  endfunction

endpackage

// File: rtl/net_code_column.sv
module net_code_column #(
  parameter int N      = 12,
  parameter int BASE_W = 4,
  parameter int CODE_W = 5,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  output logic [N-1:0]      column
);
  import net_test_pkg::*;

  for (genvar gi = 0; gi < N; gi++) begin : g_net
    localparam logic [CODE_W-1:0] CODE = CODE_W'(net_code(gi, BASE_W));
    assign column[gi] = CODE[step];
  end

endmodule

// File: rtl/net_test_seq.sv
module net_test_seq #(
  parameter int CODE_W = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              capture,
  output logic              finish,
  output logic [STEP_W-1:0] step
);
  import net_test_pkg::*;

  localparam logic [STEP_W-1:0] LAST = STEP_W'(CODE_W - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              adv_en;

  assign adv_en = start | (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    if (start) begin
      state_d = ST_RUN;
      step_d  = '0;
    end else if (state_q == ST_RUN) begin
      if (step_q == LAST) begin
        state_d = ST_DONE;
        step_d  = '0;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (adv_en) begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign done    = (state_q == ST_DONE);
  assign capture = busy & ~start;
  assign finish  = capture & (step_q == LAST);
  assign step    = step_q;

  // R1: step index never leaves the code length
  p_step_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST);

  // R2: final capture is followed by the done state
  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (state_q == ST_DONE));

  // R8: any start restarts at step 0
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && step_q == '0));

  // R7: done is held until the next start
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/net_test_judge.sv
module net_test_judge #(
  parameter int N      = 12,
  parameter int BASE_W = 4,
  parameter int CODE_W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         capture,
  input  logic         finish,
  input  logic [N-1:0] sense,
  output logic [N-1:0] open_q,
  output logic [N-1:0] short_q
);
  import net_test_pkg::*;

  logic [N-1:0] open_d, short_d;
  logic         flag_en;

  assign flag_en = clear | finish;

  for (genvar gi = 0; gi < N; gi++) begin : g_net
    localparam logic [CODE_W-1:0] OWN = CODE_W'(net_code(gi, BASE_W));
    logic [CODE_W-1:0] rx_q, rx_d;
    logic              rx_en;

    assign rx_en = clear | capture;

    always_comb begin
      rx_d = {sense[gi], rx_q[CODE_W-1:1]};
      if (clear) rx_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rx_q <= '0;
      else if (rx_en) rx_q <= rx_d;
    end

    always_comb begin
      open_d[gi]  = 1'b0;
      short_d[gi] = 1'b0;
      if (!clear) begin
        open_d[gi]  = (rx_d == '0);
        short_d[gi] = (rx_d != '0) && (rx_d != OWN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= '0;
      short_q <= '0;
    end else if (flag_en) begin
      open_q  <= open_d;
      short_q <= short_d;
    end
  end

  // R5: a net is never both open and shorted
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q & short_q) == '0);

  // R7: verdict frozen between updates
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !finish) |=> ($stable(open_q) && $stable(short_q)));

  // R7: start clears the verdict
  p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (open_q == '0 && short_q == '0));

endmodule

// File: rtl/net_test_diag.sv
module net_test_diag #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] sense,
  output logic [N-1:0] drive,
  output logic         done,
  output logic [N-1:0] open_flags,
  output logic [N-1:0] short_flags
);
  localparam int BASE_W = $clog2(N + 2);
  localparam int CODE_W = BASE_W + 1;
  localparam int STEP_W = $clog2(CODE_W);

  logic              busy, capture, finish;
  logic [STEP_W-1:0] step;
  logic [N-1:0]      column;

  initial begin
    if (N < 2) $error("net_test_diag: N must be at least 2");
  end

  net_test_seq #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .capture(capture), .finish(finish), .step(step)
  );

  net_code_column #(.N(N), .BASE_W(BASE_W), .CODE_W(CODE_W), .STEP_W(STEP_W)) u_col (
    .step(step), .column(column)
  );

  net_test_judge #(.N(N), .BASE_W(BASE_W), .CODE_W(CODE_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .clear(start), .capture(capture), .finish(finish),
    .sense(sense), .open_q(open_flags), .short_q(short_flags)
  );

  assign drive = busy ? column : '0;

  // R3: nets are quiet while a verdict is shown
  p_drive_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (drive == '0));

endmodule

// File: tb/net_test_diag_bench.sv
module net_test_diag_bench;
  localparam int N      = 12;
  localparam int BASE_W = $clog2(N + 2);
  localparam int CODE_W = BASE_W + 1;
  localparam int NV     = 8;

  // each entry: {open mask, short group A, short group B}
  localparam logic [3*N-1:0] VEC [NV] = '{
    {12'h000, 12'h000, 12'h000},
    {12'h020, 12'h000, 12'h000},
    {12'h000, 12'h044, 12'h000},
    {12'h000, 12'h003, 12'h000},
    {12'h800, 12'h218, 12'h180},
    {12'h000, 12'hFFF, 12'h000},
    {12'hFFF, 12'h000, 12'h000},
    {12'h000, 12'h005, 12'h000}
  };

  logic         clk, rst_n, start;
  logic [N-1:0] sense, drive, open_flags, short_flags;
  logic         done;
  logic [N-1:0] f_open, f_ga, f_gb;
  int checks, errors, cycles;

  net_test_diag #(.N(N)) u_net_test_diag (
    .clk(clk), .rst_n(rst_n), .start(start), .sense(sense), .drive(drive),
    .done(done), .open_flags(open_flags), .short_flags(short_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [CODE_W-1:0] exp_code(int i);
    logic [BASE_W-1:0] b;
    b = BASE_W'(i + 1);
    return {($countones(b) % 2 == 0), b};
  endfunction

  function automatic logic [N-1:0] exp_col(int s);
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) c[i] = exp_code(i)[s];
    return c;
  endfunction

  function automatic logic [N-1:0] nets(logic [N-1:0] d, logic [N-1:0] op,
                                        logic [N-1:0] ga, logic [N-1:0] gb);
    logic [N-1:0] r;
    logic a_and, b_and;
    a_and = &(d | ~ga);
    b_and = &(d | ~gb);
    for (int i = 0; i < N; i++) begin
      if (op[i])      r[i] = 1'b0;
      else if (ga[i]) r[i] = a_and;
      else if (gb[i]) r[i] = b_and;
      else            r[i] = d[i];
    end
    return r;
  endfunction

  always_comb sense = nets(drive, f_open, f_ga, f_gb);

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_flags(output logic [N-1:0] eo, output logic [N-1:0] es);
    logic [CODE_W-1:0] rx [N];
    for (int s = 0; s < CODE_W; s++) begin
      logic [N-1:0] r;
      r = nets(exp_col(s), f_open, f_ga, f_gb);
      for (int i = 0; i < N; i++) rx[i][s] = r[i];
    end
    for (int i = 0; i < N; i++) begin
      eo[i] = (rx[i] == '0);
      es[i] = (rx[i] != '0) && (rx[i] != exp_code(i));
    end
  endtask

  // currently at a negedge; start is pulsed, sequence followed to the verdict
  task automatic run_seq(input string tag);
    logic [N-1:0] eo, es;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R7 done cleared"}, N'(done), '0);
    chk({tag, " R7 flags cleared"}, open_flags | short_flags, '0);
    for (int s = 0; s < CODE_W; s++) begin
      chk({tag, " R1 drive column"}, drive, exp_col(s));
      chk({tag, " R2 done early"}, N'(done), '0);
      @(negedge clk);
    end
    expect_flags(eo, es);
    chk({tag, " R2 done due"}, N'(done), N'(1));
    chk({tag, " R4 open flags"}, open_flags, eo);
    chk({tag, " R5 short flags"}, short_flags, es);
    chk({tag, " R5 exclusive"}, open_flags & short_flags, '0);
    chk({tag, " R3 drive idle"}, drive, '0);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0;
    f_open = '0; f_ga = '0; f_gb = '0;
    repeat (3) @(negedge clk);
    chk("R9 done reset", N'(done), '0);
    chk("R9 drive reset", drive, '0);
    chk("R9 flags reset", open_flags | short_flags, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 drive idle before start", drive, '0);

    for (int v = 0; v < NV; v++) begin
      {f_open, f_ga, f_gb} = VEC[v];
      run_seq($sformatf("vec%0d", v));
      if (v == 0) chk("R6 clean board", open_flags | short_flags, '0);
    end

    // R7: verdict held while the board changes under it
    begin
      logic [N-1:0] ho, hs;
      ho = open_flags; hs = short_flags;
      f_open = 12'hAAA; f_ga = 12'h555; f_gb = '0;
      repeat (10) @(negedge clk);
      chk("R7 done held", N'(done), N'(1));
      chk("R7 open held", open_flags, ho);
      chk("R7 short held", short_flags, hs);
      chk("R3 drive quiet while held", drive, '0);
    end

    // R8: restart during a run
    f_open = 12'h001; f_ga = 12'h0C0; f_gb = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 mid-run no verdict", N'(done), '0);
    run_seq("restart R8");

    // R6 after faults clear
    f_open = '0; f_ga = '0; f_gb = '0;
    run_seq("clean again R6");
    chk("R6 clean flags", open_flags | short_flags, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule